// File: doc/BRIEF.md
# Encoded-State Serial Pattern Generator

The block plays out a stored bit pattern on one serial pin, one bit per clock, over and over. A small state register moves through a fixed cycle of codes. Each code is turned back into a position within the period, and that position selects one bit of the active pattern word. Three ways of sequencing the state can be chosen: plain binary counting, a reflected Gray sequence, and a twisted-ring (Johnson) shift register. Binary and Gray give a period of 2^STATE_W bits. Johnson gives a period of 2·JOHN_W bits.

A single-cycle flag marks the first bit of every period, so a receiver can lock to the frame. A new pattern word or a new sequencing mode may be presented at any time. Neither takes effect until the period in progress has ended, so a frame on the wire is never a mix of two settings. In binary mode several state bits can flip on the same edge. To keep the decode glitches off the pin, the serial bit in that mode is taken from a flop clocked on the falling edge.

Top module: `enc_pattern_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after release, the state is the first state (all zeros), `periodStart` is 1, and `serOut` shows bit 0 of `RESET_PAT`. The active mode is binary and the active pattern is `RESET_PAT`. `modeSel` is ignored until the first wrap.
- R2: In binary mode (`modeSel` code 0) the state counts 0, 1, … 2^STATE_W−1 and then wraps. Pattern bit k (bit k of the word, LSB = bit 0) is emitted while the state equals k.
- R3: In Gray mode (code 1) the state visits 000, 001, 011, 010, 110, 111, 101, 100 and then wraps to 000. Pattern bit k is emitted at the k-th state visited.
- R4: In Johnson mode (code 2) the register shifts left and takes the inverted top bit into bit 0. For JOHN_W=3 this gives 000, 001, 011, 111, 110, 100. The period is 2·JOHN_W, and only pattern bits 0 to 2·JOHN_W−1 are used.
- R5: In binary mode `serOut` is taken from a flop on the falling clock edge. In the half clock after a rising edge it still shows the previous bit. In Gray and Johnson modes the bit of the new state appears straight after the rising edge.
- R6: In Gray and Johnson modes at most one state bit changes on any clock edge, including the wrap.
- R7: `periodStart` is 1 for exactly one clock per period, namely the clock in which the first state is present.
- R8: A word loaded with `patLoad` becomes active only at the next wrap, and the latest load before the wrap wins. A load on the wrap edge itself takes effect at that wrap. The frame in progress is unaffected.
- R9: `modeSel` is sampled only on the wrap edge. At that edge the state restarts at all zeros. Code 3 behaves as binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 2 | Sequencing mode: 0 binary, 1 Gray, 2 Johnson, 3 binary |
| patWord | input | 2^STATE_W | Pattern word to load |
| patLoad | input | 1 | Load strobe for `patWord` |
| serOut | output | 1 | Serial pattern bit |
| periodStart | output | 1 | High during the first bit of each period |

## Verification
The assertions cover the properties that hold on every clock. In Gray and Johnson modes at most one state bit changes per edge. The binary count steps by one. The start flag never lasts two cycles. The state restarts after every wrap. The active mode and pattern change on no other edge than the wrap. The bench scenarios are needed for the rest, by comparing the serial stream bit by bit with an independent model:
- the exact order of bits for each encoding;
- the shorter Johnson period;
- the pattern and mode updates being deferred, including a load on the wrap edge and a load that overrides an earlier one;
- the half-cycle lag of the falling-edge output in binary mode.

// File: rtl/enc_pattern_pkg.sv
package enc_pattern_pkg;

  typedef enum logic [1:0] {
    MODE_BIN  = 2'd0,
    MODE_GRAY = 2'd1,
    MODE_JOHN = 2'd2,
    MODE_ALT  = 2'd3
  } modeT;

  // strobes from control to datapath
  typedef struct packed {
    logic wrap;   // current state is the last one of the period
    modeT mode;   // active sequencing mode
  } ctlT;

endpackage

// File: rtl/sergen_dp.sv
module sergen_dp
  import enc_pattern_pkg::*;
#(
  parameter int STATE_W  = 3,
  parameter int JOHN_W   = 3,
  parameter logic INIT_BIT = 1'b0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlT                       ctl,
  input  logic [(1<<STATE_W)-1:0]   actPat,
  output logic [STATE_W-1:0]        stateQ,
  output logic [STATE_W-1:0]        idx,
  output logic                      serOut
);
  localparam int PAT_W = 1 << STATE_W;

  logic [STATE_W-1:0] stateD;
  logic [STATE_W-1:0] grayBin;
  logic [STATE_W-1:0] binPlus;
  logic [STATE_W-1:0] johnIdx;
  logic [JOHN_W-1:0]  johnNext;
  logic               decBit;
  logic               negQ;
  logic               isBin;

  // Gray code back to position: each bit is the parity of itself and all bits above
  for (genvar i = 0; i < STATE_W; i++) begin : g_gray2bin
    assign grayBin[i] = ^(stateQ >> i);
  end

  assign binPlus  = grayBin + 1'b1;
  assign johnNext = {stateQ[JOHN_W-2:0], ~stateQ[JOHN_W-1]};

  // Johnson position: count of ones, folded when the top bit is set
  always_comb begin
    int ones;
    ones = 0;
    for (int i = 0; i < JOHN_W; i++) ones = ones + int'(stateQ[i]);
    if (stateQ[JOHN_W-1]) johnIdx = STATE_W'(2 * JOHN_W - ones);
    else                  johnIdx = STATE_W'(ones);
  end

  always_comb begin
    if (ctl.wrap) begin
      stateD = '0;
    end else begin
      unique case (ctl.mode)
        MODE_GRAY: stateD = binPlus ^ (binPlus >> 1);
        MODE_JOHN: stateD = STATE_W'(johnNext);
        default:   stateD = stateQ + 1'b1;
      endcase
    end
  end

  always_comb begin
    unique case (ctl.mode)
      MODE_GRAY: idx = grayBin;
      MODE_JOHN: idx = johnIdx;
      default:   idx = stateQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= '0;
    else       stateQ <= stateD;
  end

  assign decBit = actPat[idx];

  // retime on the falling edge so multi-bit transitions never reach the pin
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) negQ <= INIT_BIT;
    else       negQ <= decBit;
  end

  assign isBin  = (ctl.mode != MODE_GRAY) && (ctl.mode != MODE_JOHN);
  assign serOut = isBin ? negQ : decBit;

  logic unusedPat;
  assign unusedPat = ^{PAT_W{1'b0}};
endmodule

// File: rtl/sergen_ctrl.sv
module sergen_ctrl
  import enc_pattern_pkg::*;
#(
  parameter int STATE_W = 3,
  parameter int JOHN_W  = 3,
  parameter logic [(1<<STATE_W)-1:0] RESET_PAT = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               modeSel,
  input  logic [(1<<STATE_W)-1:0]  patWord,
  input  logic                     patLoad,
  input  logic [STATE_W-1:0]       stateQ,
  input  logic [STATE_W-1:0]       idx,
  output ctlT                      ctl,
  output logic [(1<<STATE_W)-1:0]  actPat,
  output logic                     periodStart
);
  localparam int PAT_W = 1 << STATE_W;
  localparam logic [STATE_W-1:0] BIN_LAST  = STATE_W'(PAT_W - 1);
  localparam logic [STATE_W-1:0] JOHN_LAST = STATE_W'(2 * JOHN_W - 1);

  modeT             curModeQ;
  logic [PAT_W-1:0] pendQ;
  logic             pendValidQ;
  logic [PAT_W-1:0] actPatQ;

  always_comb begin
    ctl.mode = curModeQ;
    ctl.wrap = (idx == ((curModeQ == MODE_JOHN) ? JOHN_LAST : BIN_LAST));
  end

  assign periodStart = (stateQ == '0);
  assign actPat      = actPatQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curModeQ   <= MODE_BIN;
      actPatQ    <= RESET_PAT;
      pendQ      <= RESET_PAT;
      pendValidQ <= 1'b0;
    end else if (ctl.wrap) begin
      curModeQ   <= modeT'(modeSel);
      pendValidQ <= 1'b0;
      if (patLoad)         actPatQ <= patWord;
      else if (pendValidQ) actPatQ <= pendQ;
    end else if (patLoad) begin
      pendQ      <= patWord;
      pendValidQ <= 1'b1;
    end
  end
endmodule

// File: rtl/enc_pattern_gen.sv
module enc_pattern_gen
  import enc_pattern_pkg::*;
#(
  parameter int STATE_W = 3,
  parameter int JOHN_W  = 3,
  parameter logic [(1<<STATE_W)-1:0] RESET_PAT = 8'hA5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               modeSel,
  input  logic [(1<<STATE_W)-1:0]  patWord,
  input  logic                     patLoad,
  output logic                     serOut,
  output logic                     periodStart
);
  ctlT                      ctl;
  logic [(1<<STATE_W)-1:0]  actPat;
  logic [STATE_W-1:0]       stateQ;
  logic [STATE_W-1:0]       idx;

  sergen_ctrl #(
    .STATE_W(STATE_W), .JOHN_W(JOHN_W), .RESET_PAT(RESET_PAT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .patWord(patWord),
    .patLoad(patLoad), .stateQ(stateQ), .idx(idx), .ctl(ctl),
    .actPat(actPat), .periodStart(periodStart)
  );

  sergen_dp #(
    .STATE_W(STATE_W), .JOHN_W(JOHN_W), .INIT_BIT(RESET_PAT[0])
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .actPat(actPat),
    .stateQ(stateQ), .idx(idx), .serOut(serOut)
  );
endmodule

// File: rtl/enc_pattern_gen_chk.sv
module enc_pattern_gen_chk
  import enc_pattern_pkg::*;
#(
  parameter int STATE_W = 3,
  parameter int PAT_W   = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [STATE_W-1:0] stateQ,
  input modeT               curMode,
  input logic               wrap,
  input logic [PAT_W-1:0]   actPat,
  input logic               periodStart
);
  p_bin_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_BIN && !wrap) |=> (stateQ == STATE_W'($past(stateQ) + 1'b1)));

  p_one_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_GRAY || curMode == MODE_JOHN) |=>
      ($countones(stateQ ^ $past(stateQ)) <= 1));

  p_start_once_r7: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> !periodStart);

  p_pat_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wrap |=> $stable(actPat));

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !wrap |=> $stable(curMode));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> (stateQ == '0 && periodStart));
endmodule

bind enc_pattern_gen enc_pattern_gen_chk #(
  .STATE_W(STATE_W), .PAT_W(1 << STATE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .stateQ(stateQ), .curMode(ctl.mode),
  .wrap(ctl.wrap), .actPat(actPat), .periodStart(periodStart)
);

// File: tb/enc_pattern_gen_bench.sv
module enc_pattern_gen_bench;
  localparam logic [7:0] RST_PAT = 8'hA5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'd1;
  logic [7:0] patWord = 8'h00;
  logic       patLoad = 1'b0;
  logic       serOut, periodStart;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic  bitExp;
    logic  sopExp;
    logic  earlyExp;
    string tag;
  } itemT;
  itemT q[$];

  // model state
  logic [1:0] mMode = 2'd0;
  logic [7:0] mPat = RST_PAT;
  logic [7:0] mPend = 8'h00;
  logic       mPendV = 1'b0;
  int         mPos = 0;
  logic       prevBit = RST_PAT[0];

  always #5 clk = ~clk;

  enc_pattern_gen u_enc_pattern_gen (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .patWord(patWord),
    .patLoad(patLoad), .serOut(serOut), .periodStart(periodStart)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: push expectation for the cycle in progress, then advance the model
  task automatic tick(input string tag);
    itemT it;
    int   len;
    logic binLike;
    binLike = (mMode != 2'd1) && (mMode != 2'd2);
    it.bitExp   = mPat[mPos];
    it.sopExp   = (mPos == 0);
    it.earlyExp = binLike ? prevBit : mPat[mPos];
    it.tag      = tag;
    q.push_back(it);
    prevBit = mPat[mPos];
    len = (mMode == 2'd2) ? 6 : 8;
    if (mPos == len - 1) begin
      mPos  = 0;
      mMode = modeSel;
      if (patLoad) begin
        mPat = patWord; mPendV = 1'b0;
      end else if (mPendV) begin
        mPat = mPend; mPendV = 1'b0;
      end
    end else begin
      mPos++;
      if (patLoad) begin
        mPend = patWord; mPendV = 1'b1;
      end
    end
    @(posedge clk); #2;
    patLoad = 1'b0;
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  // monitor: samples early (before the falling edge) and late in each cycle
  initial begin
    forever begin
      logic early;
      itemT it;
      @(posedge clk);
      #3 early = serOut;
      #5;
      if (q.size() > 0) begin
        it = q.pop_front();
        check({it.tag, " serial"}, serOut, it.bitExp);
        check("R7 periodStart", periodStart, it.sopExp);
        check("R5 half-cycle timing", early, it.earlyExp);
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state seen at the pins
    #12;
    check("R1 reset periodStart", periodStart, 1'b1);
    check("R1 reset serOut", serOut, RST_PAT[0]);
    @(posedge clk); #2;
    rstN = 1'b1;
    // frame 1: binary despite modeSel=Gray (R1, R2)
    ticks(8, "R1 R2");
    // frame 2: Gray with old pattern; load mid-frame (R3, R6, R8)
    ticks(3, "R3 R6");
    patWord = 8'h3C; patLoad = 1'b1;
    ticks(5, "R8 R3");
    // frame 3: Gray with new pattern; mode change to Johnson mid-frame (R9)
    ticks(2, "R8 R3 R6");
    modeSel = 2'd2;
    ticks(6, "R9 R3");
    // frame 4: Johnson, load on the wrap edge (R4, R8)
    ticks(5, "R4 R6 R9");
    patWord = 8'h5A; patLoad = 1'b1;
    tick("R4 R8");
    // frame 5: Johnson with wrap-edge load; two loads, latest wins; go to code 3
    ticks(1, "R4 R8");
    patWord = 8'h11; patLoad = 1'b1;
    tick("R4 R8");
    patWord = 8'hF0; patLoad = 1'b1;
    tick("R4 R8");
    modeSel = 2'd3;
    ticks(3, "R4 R6");
    // frame 6: code 3 behaves as binary with latest word (R9, R8, R2)
    modeSel = 2'd0;
    ticks(8, "R9 R8 R2");
    // frame 7: binary; switch to Johnson
    modeSel = 2'd2;
    patWord = 8'hC3; patLoad = 1'b1;
    ticks(8, "R2 R5");
    // frame 8: Johnson; then back to Gray
    modeSel = 2'd1;
    ticks(6, "R4 R9");
    // frame 9: Gray
    ticks(8, "R3 R6 R9");
    @(posedge clk); #9;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule